// File: doc/BRIEF.md
# Line-Coalescing Vector Gather Unit

This block serves an eight-lane gather request: it takes eight byte addresses at once and returns the eight 32-bit words stored at them as one result vector. It does not fetch one element per cycle. Each cycle it reads whole cache lines from a two-ported line memory, and it fills every waiting lane whose address falls in a line being read. The number of cycles therefore follows the locality of the addresses. Eight addresses in one line finish in a single access cycle. Eight addresses in eight different lines take four access cycles.

A request enters through a valid/ready handshake. A transfer happens on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is low from the cycle after acceptance through the cycle that presents the result. A request offered while `req_ready` is low is neither taken nor queued, so a requester that needs it must hold it until `req_ready` returns. The result side has no back-pressure: `out_valid` pulses for exactly one cycle, and the consumer must capture `out_data` in that cycle.

The memory side has two read ports. Each port carries an enable and a line index, and the memory returns the full 512-bit line on the same cycle, without a clock edge in between.

Top module: `gather_unit`

## Requirements
- R1: After reset, `req_ready` is 1, `out_valid` is 0, and both read enables are 0.
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the next cycle through the cycle in which `out_valid` is 1. A `req_valid` raised while `req_ready` is 0 has no effect on the result, and it produces no additional result.
- R3: Address bits [31:6] select the 64-byte line. Bits [5:2] select the word w, which occupies bits [32w+31:32w] of the 512-bit line. Bits [1:0] are ignored.
- R4: Lane i of the result, at `out_data[32i+31:32i]`, equals the memory word at lane i's address.
- R5: At most two lines are read per cycle. `rd_en1` is asserted only together with `rd_en0`, and only when `rd_line1` differs from `rd_line0`.
- R6: In each access cycle, port 0 reads the line of the lowest-numbered lane that is still waiting. Port 1 reads the line of the lowest-numbered waiting lane whose line differs from port 0's line. If no such lane exists, port 1 is idle.
- R7: Every waiting lane whose line is read in a cycle is filled in that cycle. The number of access cycles equals the number of distinct lines divided by two, rounded up: 1 for a single line and 4 for eight distinct lines.
- R8: `out_valid` is 1 for exactly one cycle: the cycle after the last access cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit idle, able to accept a request |
| req_addr | input | 256 | Eight byte addresses; lane i at bits [32i+31:32i] |
| rd_en0 | output | 1 | Read port 0 active |
| rd_line0 | output | 26 | Line index for port 0 |
| rd_data0 | input | 512 | Line data for port 0, returned combinationally |
| rd_en1 | output | 1 | Read port 1 active |
| rd_line1 | output | 26 | Line index for port 1 |
| rd_data1 | input | 512 | Line data for port 1, returned combinationally |
| out_valid | output | 1 | One-cycle result pulse |
| out_data | output | 256 | Gathered words; lane i at bits [32i+31:32i] |

## Verification
The assertions check the following on every cycle:
- port 1 never reads a duplicate line and never reads without port 0;
- `req_ready` falls after each acceptance;
- the result pulse lasts a single cycle;
- no gather uses more access cycles than half the lane count, rounded up.

Only the bench scenarios can show the following:
- the data in every lane is correct;
- the access-cycle count matches the number of distinct lines;
- the lowest-lane rule picks the right line on each port;
- address bits [1:0] are ignored;
- a request raised while the unit is busy is dropped.

// File: rtl/gather_pkg.sv
package gather_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } gstate_t;
endpackage

// File: rtl/gather_line_pick.sv
module gather_line_pick #(
  parameter int LANES = 8,
  parameter int LINEW = 26
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [LANES-1:0]            pend,
  input  logic [LANES-1:0][LINEW-1:0] lines,
  output logic                        sel0_ok,
  output logic [LINEW-1:0]            sel0_line,
  output logic                        sel1_ok,
  output logic [LINEW-1:0]            sel1_line
);
  always_comb begin
    sel0_ok   = 1'b0;
    sel0_line = '0;
    for (int i = 0; i < LANES; i++) begin
      if (pend[i] && !sel0_ok) begin
        sel0_ok   = 1'b1;
        sel0_line = lines[i];
      end
    end
  end

  always_comb begin
    sel1_ok   = 1'b0;
    sel1_line = '0;
    for (int i = 0; i < LANES; i++) begin
      if (pend[i] && sel0_ok && !sel1_ok && (lines[i] != sel0_line)) begin
        sel1_ok   = 1'b1;
        sel1_line = lines[i];
      end
    end
  end

  // R5
  second_line_distinct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel1_ok |-> (sel0_ok && (sel1_line != sel0_line)));
endmodule

// File: rtl/gather_lane.sv
module gather_lane #(
  parameter int LINEW = 26,
  parameter int WORD  = 32,
  parameter int WPL   = 16,
  parameter int WSELW = 4
) (
  input  logic                  pend,
  input  logic [LINEW-1:0]      line,
  input  logic [WSELW-1:0]      wsel,
  input  logic                  sel0_ok,
  input  logic [LINEW-1:0]      sel0_line,
  input  logic                  sel1_ok,
  input  logic [LINEW-1:0]      sel1_line,
  input  logic [WPL*WORD-1:0]   data0,
  input  logic [WPL*WORD-1:0]   data1,
  output logic                  hit,
  output logic [WORD-1:0]       word
);
  logic m0, m1;
  logic [WORD-1:0] w0, w1;

  assign m0  = sel0_ok && (line == sel0_line);
  assign m1  = sel1_ok && (line == sel1_line);
  assign hit = pend && (m0 || m1);

  always_comb begin
    w0 = '0;
    w1 = '0;
    for (int w = 0; w < WPL; w++) begin
      if (wsel == WSELW'(w)) begin
        w0 = data0[w*WORD +: WORD];
        w1 = data1[w*WORD +: WORD];
      end
    end
  end

  assign word = m0 ? w0 : w1;
endmodule

// File: rtl/gather_unit.sv
module gather_unit
  import gather_pkg::*;
#(
  parameter int LANES      = 8,
  parameter int AW         = 32,
  parameter int WORD       = 32,
  parameter int LINE_BYTES = 64,
  localparam int WB        = WORD / 8,
  localparam int WOFF      = $clog2(WB),
  localparam int OFFB      = $clog2(LINE_BYTES),
  localparam int WPL       = LINE_BYTES / WB,
  localparam int WSELW     = $clog2(WPL),
  localparam int LINEW     = AW - OFFB,
  localparam int LBITS     = LINE_BYTES * 8,
  localparam int MAXACC    = (LANES + 1) / 2,
  localparam int CW        = $clog2(LANES) + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [LANES*AW-1:0]   req_addr,
  output logic                  rd_en0,
  output logic [LINEW-1:0]      rd_line0,
  input  logic [LBITS-1:0]      rd_data0,
  output logic                  rd_en1,
  output logic [LINEW-1:0]      rd_line1,
  input  logic [LBITS-1:0]      rd_data1,
  output logic                  out_valid,
  output logic [LANES*WORD-1:0] out_data
);
  gstate_t state;
  logic [LANES-1:0]            pend;
  logic [LANES-1:0]            hit;
  logic [LANES-1:0][LINEW-1:0] in_line, line_q;
  logic [LANES-1:0][WSELW-1:0] in_wsel, wsel_q;
  logic [LANES-1:0][WORD-1:0]  lane_word;
  logic [LANES-1:0][WOFF-1:0]  unused_lowbits;
  logic                        s0_ok, s1_ok;
  logic [LINEW-1:0]            s0_line, s1_line;
  logic [CW-1:0]               acc_cnt;
  logic                        accept;

  assign accept    = req_valid && req_ready;
  assign req_ready = (state == ST_IDLE);
  assign out_valid = (state == ST_DONE);

  for (genvar i = 0; i < LANES; i++) begin : g_split
    assign in_line[i]        = req_addr[i*AW + OFFB +: LINEW];
    assign in_wsel[i]        = req_addr[i*AW + WOFF +: WSELW];
    assign unused_lowbits[i] = req_addr[i*AW +: WOFF];
  end

  gather_line_pick #(.LANES(LANES), .LINEW(LINEW)) u_pick (
    .clk(clk), .rst_n(rst_n), .pend(pend), .lines(line_q),
    .sel0_ok(s0_ok), .sel0_line(s0_line),
    .sel1_ok(s1_ok), .sel1_line(s1_line)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    gather_lane #(.LINEW(LINEW), .WORD(WORD), .WPL(WPL), .WSELW(WSELW)) u_lane (
      .pend(pend[i]), .line(line_q[i]), .wsel(wsel_q[i]),
      .sel0_ok(s0_ok), .sel0_line(s0_line),
      .sel1_ok(s1_ok), .sel1_line(s1_line),
      .data0(rd_data0), .data1(rd_data1),
      .hit(hit[i]), .word(lane_word[i])
    );
  end

  assign rd_en0   = (state == ST_RUN) && s0_ok;
  assign rd_en1   = (state == ST_RUN) && s1_ok;
  assign rd_line0 = s0_line;
  assign rd_line1 = s1_line;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      pend    <= '0;
      line_q  <= '0;
      wsel_q  <= '0;
      acc_cnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          line_q  <= in_line;
          wsel_q  <= in_wsel;
          pend    <= '1;
          acc_cnt <= '0;
          state   <= ST_RUN;
        end
        ST_RUN: begin
          pend    <= pend & ~hit;
          acc_cnt <= acc_cnt + 1'b1;
          if ((pend & ~hit) == '0) state <= ST_DONE;
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_res
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_data[i*WORD +: WORD] <= '0;
      else if (state == ST_RUN && hit[i]) out_data[i*WORD +: WORD] <= lane_word[i];
    end
  end

  // R2
  ready_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);
  // R5
  port1_needs_port0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en1 |-> rd_en0);
  // R7
  access_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en0 |-> (acc_cnt < CW'(MAXACC)));
  // R8
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
endmodule

// File: tb/gather_unit_test.sv
module gather_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic         clk = 0;
  logic         rst_n = 0;
  logic         req_valid = 0;
  logic         req_ready;
  logic [255:0] req_addr = '0;
  logic         rd_en0, rd_en1;
  logic [25:0]  rd_line0, rd_line1;
  logic [511:0] rd_data0, rd_data1;
  logic         out_valid;
  logic [255:0] out_data;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gather_unit uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .rd_en0(rd_en0), .rd_line0(rd_line0), .rd_data0(rd_data0),
    .rd_en1(rd_en1), .rd_line1(rd_line1), .rd_data1(rd_data1),
    .out_valid(out_valid), .out_data(out_data)
  );

  function automatic logic [31:0] memw(input logic [25:0] ln, input int w);
    return ({6'b0, ln} * 32'h9E3779B1) ^ (32'(w) * 32'h01000193) ^ 32'h5A5A0000;
  endfunction

  always_comb begin
    for (int w = 0; w < 16; w++) begin
      rd_data0[w*32 +: 32] = memw(rd_line0, w);
      rd_data1[w*32 +: 32] = memw(rd_line1, w);
    end
  end

  logic [255:0] exp_q[$];
  int           acc_q[$];
  logic [25:0]  l0_q[$];
  logic [25:0]  l1_q[$];
  bit           e1_q[$];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push_expect(input logic [31:0] a [N]);
    logic [255:0] ev;
    logic [25:0]  ln [N];
    int           distinct;
    bit           seen;
    bit           has1;
    logic [25:0]  l1;
    for (int i = 0; i < N; i++) begin
      ln[i] = a[i][31:6];
      ev[i*32 +: 32] = memw(ln[i], int'(a[i][5:2]));
    end
    distinct = 0;
    for (int i = 0; i < N; i++) begin
      seen = 0;
      for (int j = 0; j < i; j++) if (ln[j] == ln[i]) seen = 1;
      if (!seen) distinct++;
    end
    has1 = 0; l1 = '0;
    for (int i = 0; i < N; i++) if (!has1 && ln[i] != ln[0]) begin has1 = 1; l1 = ln[i]; end
    exp_q.push_back(ev);
    acc_q.push_back((distinct + 1) / 2);
    l0_q.push_back(ln[0]);
    l1_q.push_back(l1);
    e1_q.push_back(has1);
  endtask

  task automatic drive(input logic [31:0] a [N]);
    @(posedge clk); #1;
    push_expect(a);
    for (int i = 0; i < N; i++) req_addr[i*32 +: 32] = a[i];
    req_valid = 1;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  bit busy = 0, first = 0, prev_valid = 0;
  int acc = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (first) begin
        first = 0;
        check(rd_en0 == 1 && rd_line0 == l0_q[0], "R6", "port0 line", rd_line0, l0_q[0]);
        check(rd_en1 == e1_q[0], "R6", "port1 enable", rd_en1, e1_q[0]);
        if (e1_q[0]) check(rd_line1 == l1_q[0], "R6", "port1 line", rd_line1, l1_q[0]);
      end
      if (busy) check(!req_ready, "R2", "ready while busy", req_ready, 0);
      if (rd_en1) check(rd_en0 && rd_line1 != rd_line0, "R5", "port1 duplicate", rd_line1, rd_line0);
      if (rd_en0) acc++;
      if (out_valid) begin
        check(!prev_valid, "R8", "pulse longer than one cycle", 1, 0);
        if (exp_q.size() == 0) begin
          check(0, "R2", "stray result", 1, 0);
        end else begin
          for (int i = 0; i < N; i++)
            check(out_data[i*32 +: 32] == exp_q[0][i*32 +: 32], "R4", $sformatf("lane %0d", i),
                  out_data[i*32 +: 32], exp_q[0][i*32 +: 32]);
          check(acc == acc_q[0], "R7", "access cycles", acc, acc_q[0]);
          void'(exp_q.pop_front()); void'(acc_q.pop_front());
          void'(l0_q.pop_front()); void'(l1_q.pop_front()); void'(e1_q.pop_front());
        end
        busy = 0;
      end
      prev_valid = out_valid;
      if (req_valid && req_ready) begin busy = 1; first = 1; acc = 0; end
    end
  end

  logic [31:0] a [N];
  logic [31:0] seed = 32'h1234_5678;

  function automatic logic [31:0] nextr(inout logic [31:0] s);
    s = s * 32'd1664525 + 32'd1013904223;
    return s;
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(req_ready == 1, "R1", "ready after reset", req_ready, 1);
    check(out_valid == 0 && rd_en0 == 0 && rd_en1 == 0, "R1", "idle outputs",
          {out_valid, rd_en0, rd_en1}, 0);

    // R7 single line, one access
    a = '{32'h1000 + 7*4, 32'h1000, 32'h1000 + 12, 32'h1000 + 12,
          32'h1000 + 60, 32'h1004, 32'h1000 + 36, 32'h1008};
    drive(a);
    // R7 eight distinct lines, four accesses
    for (int i = 0; i < N; i++) a[i] = 32'h0002_0000 + i * 32'h440 + 4 * i;
    drive(a);
    // R6 three lines, mixed order
    a = '{32'h3000, 32'h5040, 32'h3008, 32'h7f00, 32'h5044, 32'h3010, 32'h7f3c, 32'h5040};
    drive(a);
    // five lines
    a = '{32'h9000, 32'h9040, 32'h9080, 32'h9000, 32'h90c0, 32'h9100, 32'h9044, 32'h9104};
    drive(a);
    // R3 low address bits ignored
    a = '{32'h4003, 32'h4005, 32'h400a, 32'h400f, 32'h4011, 32'h403e, 32'h4021, 32'h4032};
    drive(a);
    // R2 request while busy is dropped
    for (int i = 0; i < N; i++) a[i] = 32'h0040_0000 + i * 32'h1000;
    drive(a);
    @(posedge clk); #1;
    for (int i = 0; i < N; i++) req_addr[i*32 +: 32] = 32'hdead_0000 + i * 4;
    req_valid = 1;
    @(posedge clk); #1;
    @(posedge clk); #1;
    req_valid = 0;
    while (exp_q.size() != 0) @(posedge clk);
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(exp_q.size() == 0 && !out_valid, "R2", "no extra result", out_valid, 0);

    // random gathers with locality
    for (int t = 0; t < 40; t++) begin
      for (int i = 0; i < N; i++) begin
        logic [31:0] r;
        r = nextr(seed);
        a[i] = {18'h0, 2'(r[7:6] & ((t % 3 == 0) ? 2'b00 : 2'b11)), r[17:14], 8'h0} |
               {26'h0, r[25:20]};
        a[i] = a[i] + 32'((t % 4) * 64);
      end
      drive(a);
    end
    while (exp_q.size() != 0) @(posedge clk);
    repeat (3) @(posedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule